// File: doc/BRIEF.md
# Converter Self-Calibration Sequencer

This block drives a complete internal calibration sweep of a sigma-delta converter through a register-access engine that owns the serial bus. After a start pulse it walks eight steps: zero-scale and then full-scale internal calibration on each of four single-ended inputs. For each step it sends three register writes to the access engine. The first selects the input. The second starts the calibration and keeps chip select asserted. The third, sent once the converter reports ready, returns the converter to idle. Each write is handed to the engine over a request/acknowledge handshake.

The base mode and configuration words are captured at start. Only the mode-select field and the channel field change from step to step. A clock-divide bit is added to the calibration word unless the device variant code is the exempt one. An error acknowledge, or a ready indication that does not arrive in time, ends the sweep at once. A done pulse marks the end of every sweep, and fail is raised with it when the sweep was aborted.

Top module: `cal_seq_top`

## Requirements
- R1: After reset, req_o, done_o and fail_o are low and no request is made until start_i is seen.
- R2: A sweep issues 24 writes in 8 steps. Each step is a channel write, then a calibration write, then an idle write. The steps alternate mode-select 4 (zero-scale) and 5 (full-scale), with both steps for one input before moving on. The inputs have channel codes 4, 5, 6 and 7, taken in that order.
- R3: A channel write uses address 2 and hold 0. Its data is the captured configuration word with bits 15:8 replaced by the one-hot value 1<<code.
- R4: A calibration write uses address 1 and hold 1. Its data is the captured mode word with bits 23:21 set to the step's mode-select; all other bits are unchanged, apart from R5.
- R5: Bit 12 of the calibration word is forced to 1 whenever variant_i is not 4'h6. When variant_i is 4'h6, bit 12 keeps the value it has in the captured mode word.
- R6: The idle write uses address 1 and hold 0. Its data is the captured mode word with bits 23:21 = 2 and no bit-12 insertion. It is issued only after rdy_i is seen high while the sweep is waiting. rdy_i is ignored at all other times.
- R7: A request keeps req_o, req_addr_o, req_data_o and req_hold_cs_o stable until the cycle in which ack_i is high. A write completes on a clock edge where req_o and ack_i are both high.
- R8: On success, done_o is high for exactly one cycle, in the cycle after the last idle write completes, and fail_o stays low.
- R9: A write completed with err_i high aborts the sweep. No further request follows, and done_o and fail_o are both high in the next cycle.
- R10: The wait for ready lasts at most TIMEOUT_CYC clock edges. Ready seen on edge TIMEOUT_CYC still counts. If ready is not seen by then, the sweep aborts with no further request, and done_o and fail_o go high one cycle later.
- R11: start_i during a sweep is ignored, and changes to the base words or variant_i during a sweep have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a sweep when idle |
| variant_i | input | 4 | Device variant code, captured at start |
| mode_base_i | input | 24 | Mode word, captured at start |
| conf_base_i | input | 24 | Configuration word, captured at start |
| req_o | output | 1 | Register write request |
| req_addr_o | output | 3 | Register address of the write |
| req_data_o | output | 24 | Data of the write |
| req_hold_cs_o | output | 1 | Keep chip select asserted after this write |
| ack_i | input | 1 | Write accepted and completed |
| err_i | input | 1 | Write failed; valid with ack_i |
| rdy_i | input | 1 | Conversion or calibration complete |
| done_o | output | 1 | One-cycle end-of-sweep pulse |
| fail_o | output | 1 | Sweep aborted; valid with done_o |

## Verification
The checker watches every cycle for five things. A pending request must stay stable. Every channel write must carry exactly one channel bit. Every calibration write must target the mode register with mode-select 4 or 5, and must carry the divide bit when the variant requires it. A completed calibration write must be followed by a gap with no request. done_o must be a lone pulse, with fail_o high only alongside it. Four other properties only the bench scenarios can show: the full write order with exact words, the ready-timeout boundary, abort on an error acknowledge at a chosen write, and the ignored start and base-word changes during a sweep. The bench checks these against a transaction-queue model on every clock, with varied acknowledge latency and noise on the ready line.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  localparam int WORD_W  = 24;
  localparam int ADDR_W  = 3;
  localparam int SEL_LSB = 21;
  localparam int SEL_W   = 3;
  localparam int CHAN_LSB = 8;
  localparam int CHAN_W  = 8;
  localparam int DIV_BIT = 12;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CONF = 3'd2;

  localparam logic [SEL_W-1:0] SEL_IDLE     = 3'd2;
  localparam logic [SEL_W-1:0] SEL_CAL_ZERO = 3'd4;
  localparam logic [SEL_W-1:0] SEL_CAL_FULL = 3'd5;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONF,
    ST_MODE,
    ST_WAIT,
    ST_RESTORE,
    ST_FIN
  } seq_state_e;
endpackage

// File: rtl/cal_entry_rom.sv
module cal_entry_rom
  import cal_seq_pkg::*;
#(
  parameter int ENTRY_W    = 3,
  parameter int FIRST_CHAN = 4
) (
  input  logic [ENTRY_W-1:0] idx_i,
  output logic [SEL_W-1:0]   msel_o,
  output logic [CHAN_W-1:0]  chan_onehot_o
);
  localparam int CODE_W = $clog2(CHAN_W) + 1;

  logic [CODE_W-1:0] code;

  // even entries calibrate zero-scale, odd entries full-scale on the same input
  assign msel_o = idx_i[0] ? SEL_CAL_FULL : SEL_CAL_ZERO;
  assign code   = CODE_W'(FIRST_CHAN) + CODE_W'(idx_i >> 1);

  for (genvar g = 0; g < CHAN_W; g++) begin : g_onehot
    assign chan_onehot_o[g] = (code == CODE_W'(g));
  end
endmodule

// File: rtl/cal_word_build.sv
module cal_word_build
  import cal_seq_pkg::*;
#(
  parameter bit         CLKDIV_EN     = 1'b1,
  parameter logic [3:0] NODIV_VARIANT = 4'h6
) (
  input  seq_state_e         phase_i,
  input  word_t              mode_base_i,
  input  word_t              conf_base_i,
  input  logic [3:0]         variant_i,
  input  logic [SEL_W-1:0]   msel_i,
  input  logic [CHAN_W-1:0]  chan_onehot_i,
  output logic [ADDR_W-1:0]  addr_o,
  output word_t              data_o,
  output logic               hold_o
);
  word_t sel_clr, conf_w, cal_w, idle_w;
  logic  div_set;

  if (CLKDIV_EN) begin : g_div
    assign div_set = (variant_i != NODIV_VARIANT);
  end else begin : g_nodiv
    assign div_set = 1'b0;
  end

  always_comb begin
    sel_clr = mode_base_i;
    sel_clr[SEL_LSB +: SEL_W] = '0;

    conf_w = conf_base_i;
    conf_w[CHAN_LSB +: CHAN_W] = chan_onehot_i;

    cal_w = sel_clr;
    cal_w[SEL_LSB +: SEL_W] = msel_i;
    if (div_set) cal_w[DIV_BIT] = 1'b1;

    idle_w = sel_clr;
    idle_w[SEL_LSB +: SEL_W] = SEL_IDLE;

    unique case (phase_i)
      ST_CONF: begin addr_o = ADDR_CONF; data_o = conf_w; hold_o = 1'b0; end
      ST_MODE: begin addr_o = ADDR_MODE; data_o = cal_w;  hold_o = 1'b1; end
      default: begin addr_o = ADDR_MODE; data_o = idle_w; hold_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/cal_ready_timer.sv
module cal_ready_timer #(
  parameter int LIMIT = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top
  import cal_seq_pkg::*;
#(
  parameter int         NUM_INPUTS    = 4,
  parameter int         FIRST_CHAN    = 4,
  parameter int         TIMEOUT_CYC   = 100000,
  parameter bit         CLKDIV_EN     = 1'b1,
  parameter logic [3:0] NODIV_VARIANT = 4'h6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [3:0]        variant_i,
  input  logic [WORD_W-1:0] mode_base_i,
  input  logic [WORD_W-1:0] conf_base_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [WORD_W-1:0] req_data_o,
  output logic              req_hold_cs_o,
  input  logic              ack_i,
  input  logic              err_i,
  input  logic              rdy_i,
  output logic              done_o,
  output logic              fail_o
);
  localparam int NUM_ENTRIES = 2 * NUM_INPUTS;
  localparam int ENTRY_W     = $clog2(NUM_ENTRIES);
  localparam logic [ENTRY_W-1:0] LAST_ENTRY = ENTRY_W'(NUM_ENTRIES - 1);

  seq_state_e          state_q, state_d;
  logic [ENTRY_W-1:0]  idx_q, idx_d;
  logic                fail_q, fail_d;
  word_t               mode_q, conf_q;
  logic [3:0]          variant_q;
  logic [SEL_W-1:0]    msel;
  logic [CHAN_W-1:0]   chan_onehot;
  logic                expired;
  logic                xfer;

  cal_entry_rom #(.ENTRY_W(ENTRY_W), .FIRST_CHAN(FIRST_CHAN)) u_rom (
    .idx_i        (idx_q),
    .msel_o       (msel),
    .chan_onehot_o(chan_onehot)
  );

  cal_word_build #(.CLKDIV_EN(CLKDIV_EN), .NODIV_VARIANT(NODIV_VARIANT)) u_build (
    .phase_i      (state_q),
    .mode_base_i  (mode_q),
    .conf_base_i  (conf_q),
    .variant_i    (variant_q),
    .msel_i       (msel),
    .chan_onehot_i(chan_onehot),
    .addr_o       (req_addr_o),
    .data_o       (req_data_o),
    .hold_o       (req_hold_cs_o)
  );

  cal_ready_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_WAIT),
    .expired_o(expired)
  );

  assign req_o  = (state_q == ST_CONF) || (state_q == ST_MODE) || (state_q == ST_RESTORE);
  assign xfer   = req_o && ack_i;
  assign done_o = (state_q == ST_FIN);
  assign fail_o = done_o && fail_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    fail_d  = fail_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_CONF;
        idx_d   = '0;
        fail_d  = 1'b0;
      end
      ST_CONF: if (xfer) begin
        if (err_i) begin state_d = ST_FIN; fail_d = 1'b1; end
        else state_d = ST_MODE;
      end
      ST_MODE: if (xfer) begin
        if (err_i) begin state_d = ST_FIN; fail_d = 1'b1; end
        else state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rdy_i) state_d = ST_RESTORE;
        else if (expired) begin state_d = ST_FIN; fail_d = 1'b1; end
      end
      ST_RESTORE: if (xfer) begin
        if (err_i) begin state_d = ST_FIN; fail_d = 1'b1; end
        else if (idx_q == LAST_ENTRY) state_d = ST_FIN;
        else begin state_d = ST_CONF; idx_d = idx_q + 1'b1; end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      fail_q  <= fail_d;
    end
  end

  // base words captured once per sweep
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= '0;
      conf_q    <= '0;
      variant_q <= '0;
    end else if (state_q == ST_IDLE && start_i) begin
      mode_q    <= mode_base_i;
      conf_q    <= conf_base_i;
      variant_q <= variant_i;
    end
  end
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk
  import cal_seq_pkg::*;
#(
  parameter logic [3:0] NODIV_VARIANT = 4'h6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        variant_i,
  input logic              req_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [WORD_W-1:0] req_data_o,
  input logic              req_hold_cs_o,
  input logic              ack_i,
  input logic              done_o,
  input logic              fail_o
);
  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(req_addr_o) && $stable(req_data_o) && $stable(req_hold_cs_o));

  p_conf_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && req_addr_o == ADDR_CONF |-> $countones(req_data_o[CHAN_LSB +: CHAN_W]) == 1 && !req_hold_cs_o);

  p_cal_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && req_hold_cs_o |-> req_addr_o == ADDR_MODE &&
      (req_data_o[SEL_LSB +: SEL_W] == SEL_CAL_ZERO || req_data_o[SEL_LSB +: SEL_W] == SEL_CAL_FULL));

  p_div_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && req_hold_cs_o && variant_i != NODIV_VARIANT |-> req_data_o[DIV_BIT]);

  p_wait_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i && req_hold_cs_o |=> !req_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_fail_with_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o && !req_o);
endmodule

bind cal_seq_top cal_seq_chk #(.NODIV_VARIANT(NODIV_VARIANT)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .variant_i    (variant_i),
  .req_o        (req_o),
  .req_addr_o   (req_addr_o),
  .req_data_o   (req_data_o),
  .req_hold_cs_o(req_hold_cs_o),
  .ack_i        (ack_i),
  .done_o       (done_o),
  .fail_o       (fail_o)
);

// File: tb/cal_seq_top_tb_top.sv
`timescale 1ns/1ps
module cal_seq_top_tb_top;
  localparam int TO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  variant = 4'h0;
  logic [23:0] mode_base = '0, conf_base = '0;
  logic        req, hold, done, fail;
  logic [2:0]  addr;
  logic [23:0] data;
  logic        ack = 1'b0, err = 1'b0, rdy = 1'b0;

  always #2 clk = ~clk;

  cal_seq_top #(.TIMEOUT_CYC(TO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .variant_i(variant),
    .mode_base_i(mode_base), .conf_base_i(conf_base),
    .req_o(req), .req_addr_o(addr), .req_data_o(data), .req_hold_cs_o(hold),
    .ack_i(ack), .err_i(err), .rdy_i(rdy), .done_o(done), .fail_o(fail)
  );

  typedef struct { int a; int d; bit h; } txn_t;
  txn_t exp_q[$];

  int checks = 0, failures = 0;
  // scenario knobs
  int ack_lat = 0, rdy_lat = 1, err_at = -1, to_entry = -1;
  bit noise = 1'b0;
  // model state
  bit sweeping = 1'b0;
  int txn_no = 0, ack_wait = 0;
  int rdy_cd = 0, done_cd = 0;
  bit rdy_arm = 1'b0, done_arm = 1'b0, fail_exp = 1'b0;
  bit prev_req = 1'b0, prev_ack = 1'b0, prev_hold = 1'b0;
  logic [2:0] prev_addr;
  logic [23:0] prev_data;

  task automatic chk(bit ok, string req_tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req_tag, act, expv);
    end
  endtask

  function automatic int with_sel(int w, int s);
    return (w & ~(7 << 21)) | (s << 21);
  endfunction

  task automatic push_sweep();
    for (int inp = 0; inp < 4; inp++) begin
      for (int z = 0; z < 2; z++) begin
        txn_t t;
        int cal;
        t.a = 2; t.h = 1'b0;
        t.d = (int'(conf_base) & ~(32'hFF << 8)) | ((1 << (4 + inp)) << 8);
        exp_q.push_back(t);
        cal = with_sel(int'(mode_base), 4 + z);
        if (variant != 4'h6) cal = cal | (1 << 12);
        t.a = 1; t.h = 1'b1; t.d = cal;
        exp_q.push_back(t);
        t.a = 1; t.h = 1'b0; t.d = with_sel(int'(mode_base), 2);
        exp_q.push_back(t);
      end
    end
  endtask

  task automatic run_sweep();
    @(negedge clk);
    push_sweep();
    txn_no = 0;
    sweeping = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    while (sweeping) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // responder and per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_d;
      if (done_cd > 0) done_cd--;
      if (rdy_cd > 0) rdy_cd--;
      exp_d = done_arm && done_cd == 0;
      // R8 R9 R10: done/fail exactly when the model ends the sweep
      chk(done == exp_d && fail == (exp_d && fail_exp), "R8/R9/R10 done,fail",
          {done, fail}, {exp_d, exp_d && fail_exp});
      if (exp_d) begin done_arm = 1'b0; sweeping = 1'b0; end

      if (req && exp_q.size() == 0) chk(1'b0, "R2/R9 unexpected request", req, 0);
      if (req && (rdy_arm || done_arm)) chk(1'b0, "R6/R10 request during wait", req, 0);
      if (prev_req && !prev_ack)
        chk(req && addr == prev_addr && data == prev_data && hold == prev_hold,
            "R7 held request", {req, addr, data}, {1'b1, prev_addr, prev_data});

      if (rdy_arm && rdy_cd == 0) begin rdy = 1'b1; rdy_arm = 1'b0; end
      else rdy = noise && req; // R6: ready outside the wait is ignored

      ack = 1'b0; err = 1'b0;
      if (req && exp_q.size() > 0) begin
        if (ack_wait >= ack_lat) begin
          txn_t t;
          t = exp_q.pop_front();
          ack = 1'b1;
          err = (txn_no == err_at);
          chk(int'(addr) == t.a && int'(data) == t.d && hold == t.h,
              "R2/R3/R4/R5/R6 write word", {addr, data, hold}, {t.a[2:0], t.d[23:0], t.h});
          if (err) begin
            exp_q.delete(); done_arm = 1'b1; done_cd = 1; fail_exp = 1'b1;
          end else if (txn_no % 3 == 1) begin
            if (txn_no / 3 == to_entry) begin
              exp_q.delete(); done_arm = 1'b1; done_cd = TO + 1; fail_exp = 1'b1;
            end else begin
              rdy_arm = 1'b1; rdy_cd = rdy_lat;
            end
          end else if (exp_q.size() == 0) begin
            done_arm = 1'b1; done_cd = 1; fail_exp = 1'b0;
          end
          txn_no++;
          ack_wait = 0;
        end else ack_wait++;
      end else ack_wait = 0;

      prev_req = req; prev_ack = ack; prev_addr = addr; prev_data = data; prev_hold = hold;
    end
  end

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req == 1'b0 && done == 1'b0 && fail == 1'b0, "R1 reset outputs", {req, done, fail}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req == 1'b0 && done == 1'b0, "R1 quiet before start", {req, done}, 0);

    // R2 R3 R4 R5 R6 R8: divide inserted, fast acks
    variant = 4'h0; mode_base = 24'h0801E0; conf_base = 24'h900018;
    ack_lat = 0; rdy_lat = 3; noise = 1'b0;
    run_sweep(); wait_end();

    // R5: exempt variant, divide bit not forced; R7 slow acks; R6 ready noise
    variant = 4'h6; mode_base = 24'h0C0123; conf_base = 24'h10FF47;
    ack_lat = 2; rdy_lat = 1; noise = 1'b1;
    run_sweep(); wait_end();

    // R5: exempt variant with base divide bit already set keeps it
    mode_base = 24'hFFF3FF; conf_base = 24'h000000; ack_lat = 1; noise = 1'b0;
    run_sweep(); wait_end();

    // R10: ready on the last allowed edge still succeeds
    variant = 4'h4; mode_base = 24'h000000; conf_base = 24'hFFFFFF;
    ack_lat = 0; rdy_lat = TO;
    run_sweep(); wait_end();

    // R9: error on the calibration write of the second step
    rdy_lat = 2; err_at = 4;
    run_sweep(); wait_end();
    err_at = 20; // error on an idle write late in the sweep
    run_sweep(); wait_end();
    err_at = -1;

    // R10: ready never arrives on step 2
    to_entry = 2;
    run_sweep(); wait_end();
    to_entry = -1;

    // R11: start and base changes mid-sweep ignored
    mode_base = 24'h123456; conf_base = 24'h654321; variant = 4'h2; ack_lat = 1;
    run_sweep();
    repeat (20) @(negedge clk);
    start = 1'b1; mode_base = 24'hABCDEF; conf_base = 24'h00AA00;
    @(negedge clk);
    start = 1'b0;
    wait_end();
    chk(exp_q.size() == 0 && req == 1'b0, "R11 sweep unchanged", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule